// File: doc/BRIEF.md
# Replayable Multi-Port Issue Queue

This block is a circular instruction queue for one execution class of one thread. Each cycle a front end offers up to four instruction lanes. Each lane carries its own valid bit, and squashed slots arrive with that bit cleared. The queue packs the valid lanes into consecutive entries. It presents the oldest pending instructions on up to two issue ports, strictly in program order.

Issuing an instruction does not free its entry. The entry stays until the back end reports it retired. When the back end asks for a replay, the queue rewinds its issue pointer to the oldest unretired entry and presents the same instructions again from its own storage, so the pipeline never stalls. A flush empties the queue outright. The queue raises backpressure while too little room remains for a full write group. Its read pointer belongs to it alone, and nothing orders it against sibling class queues.

The depth must be a power of two. Outputs depend only on registered state: there is no combinational path from input to output.

Top module: `iq_replay_queue`

## Requirements
- R1: After synchronous reset the queue is empty: both issue valids are low and backpressure is low.
- R2: In a write cycle, the valid lanes of `in_vld` are stored in ascending lane order into consecutive entries following the newest one. Lane k's data is bits [32k+31:32k] of `in_data`. Invalid lanes occupy no entry.
- R3: Issue port p (data bits [32p+31:32p] of `iss_data_o`) shows the p-th oldest entry that is written but not yet issued. `iss_vld_o[1]` is never high unless `iss_vld_o[0]` is high.
- R4: Port 0 is accepted when its valid and ready bits are both high. Port 1 is accepted only when port 0 is accepted in the same cycle. The issue position advances by the number of accepted ports.
- R5: An issued entry keeps its place, counting towards occupancy, until `ret_cnt_i` (0 to 2, never more than the issued-but-unretired count) frees the oldest entries.
- R6: `bp_o` is high exactly when fewer than 4 of the 32 entries are unoccupied, counting issued-but-unretired entries as occupied. While it is high, all offered lanes are dropped and no entry is overwritten.
- R7: On `replay_i` without flush, the issue position returns to the oldest entry still unretired after that cycle's retirement. Issue acceptances in that cycle are discarded, and the next cycle presents that entry again on port 0.
- R8: `flush_i` empties the queue in one cycle. It overrides replay, retirement and writes arriving in the same cycle.
- R9: The queue wraps around its 32 entries indefinitely and keeps program order across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 4 | Per-lane valid bits of the offered group |
| in_data | input | 128 | Lane payloads, lane k in bits [32k+31:32k] |
| bp_o | output | 1 | Backpressure: fewer than 4 entries free |
| iss_vld_o | output | 2 | Per-port issue valid |
| iss_data_o | output | 64 | Issue payloads, port p in bits [32p+31:32p] |
| iss_rdy_i | input | 2 | Per-port acceptance from the execution ports |
| ret_cnt_i | input | 2 | Number of oldest issued entries retired this cycle |
| replay_i | input | 1 | Rewind issue to the oldest unretired entry |
| flush_i | input | 1 | Empty the queue |

## Verification
The bench drives lane masks with gaps (1010, 0110, 0001, 0000) and then reads the payloads back through issue. A payload that appears out of sequence means compaction ordered the lanes wrongly or left a hole. Ready patterns with only port 1 ready tell apart a correct in-order issue from one that skips ahead. Replay combined with retirement in the same cycle separates rewinding to the old retire position from rewinding to the new one. Filling the queue with nothing retired exposes the backpressure threshold and dropped writes. A long random phase with rare flushes and replays then drives the pointers through many wraps of the 32 entries.

// File: rtl/iq_pkg.sv
package iq_pkg;
  localparam int IQ_DEPTH = 32;
  localparam int IQ_LANES = 4;
  localparam int IQ_PORTS = 2;
  localparam int IQ_DW    = 32;
endpackage

// File: rtl/iq_compact.sv
module iq_compact #(
  parameter int LANES = 4,
  parameter int DW    = 32
) (
  input  logic [LANES-1:0]               lane_vld,
  input  logic [LANES*DW-1:0]            lane_dat,
  output logic [LANES-1:0]               slot_vld,
  output logic [LANES*DW-1:0]            slot_dat,
  output logic [$clog2(LANES+1)-1:0]     count
);
  localparam int CW = $clog2(LANES+1);

  logic [CW-1:0] rank [LANES];
  logic [CW-1:0] acc;

  // rank of a lane = number of valid lanes below it
  always_comb begin
    acc = '0;
    for (int l = 0; l < LANES; l++) begin
      rank[l] = acc;
      acc = acc + CW'(lane_vld[l]);
    end
    count = acc;
  end

  always_comb begin
    slot_vld = '0;
    slot_dat = '0;
    for (int k = 0; k < LANES; k++) begin
      for (int l = 0; l < LANES; l++) begin
        if (lane_vld[l] && rank[l] == CW'(k)) begin
          slot_vld[k]            = 1'b1;
          slot_dat[k*DW +: DW]   = lane_dat[l*DW +: DW];
        end
      end
    end
  end
endmodule

// File: rtl/iq_store.sv
module iq_store #(
  parameter int DEPTH = 32,
  parameter int DW    = 32,
  parameter int LANES = 4,
  parameter int PORTS = 2,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic [LANES-1:0]    we,
  input  logic [LANES*AW-1:0] wa,
  input  logic [LANES*DW-1:0] wd,
  input  logic [PORTS*AW-1:0] ra,
  output logic [PORTS*DW-1:0] rd
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int k = 0; k < LANES; k++) begin
      if (we[k]) mem[wa[k*AW +: AW]] <= wd[k*DW +: DW];
    end
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_rd
    assign rd[p*DW +: DW] = mem[ra[p*AW +: AW]];
  end
endmodule

// File: rtl/iq_ptrs.sv
module iq_ptrs #(
  parameter int DEPTH = 32,
  parameter int LANES = 4,
  parameter int PORTS = 2,
  parameter int PW    = $clog2(DEPTH) + 1,
  parameter int LCW   = $clog2(LANES+1),
  parameter int PCW   = $clog2(PORTS+1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [LCW-1:0] wr_cnt,
  input  logic [PCW-1:0] iss_cnt,
  input  logic [PCW-1:0] ret_cnt,
  input  logic           replay,
  input  logic           flush,
  output logic [PW-1:0]  wr_ptr,
  output logic [PW-1:0]  iss_ptr,
  output logic [PW-1:0]  ret_ptr,
  output logic [PW-1:0]  pend,
  output logic           bp
);
  logic [PW-1:0] occ, free_n, ret_nxt;

  assign occ     = wr_ptr - ret_ptr;
  assign free_n  = PW'(DEPTH) - occ;
  assign pend    = wr_ptr - iss_ptr;
  assign bp      = free_n < PW'(LANES);
  assign ret_nxt = ret_ptr + PW'(ret_cnt);

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr  <= '0;
      iss_ptr <= '0;
      ret_ptr <= '0;
    end else begin
      wr_ptr  <= wr_ptr + PW'(wr_cnt);
      ret_ptr <= ret_nxt;
      iss_ptr <= replay ? ret_nxt : iss_ptr + PW'(iss_cnt);
    end
  end

  // R6: occupancy never exceeds the storage
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_ptr - ret_ptr) <= PW'(DEPTH));
  // R5: retirement stays within issued-but-unretired entries
  p_retire_bound_r5: assert property (@(posedge clk) disable iff (rst)
    !flush |-> PW'(ret_cnt) <= (iss_ptr - ret_ptr));
  // R3: issue position stays between retire and write positions
  p_iss_window_r3: assert property (@(posedge clk) disable iff (rst)
    (iss_ptr - ret_ptr) <= (wr_ptr - ret_ptr));
  // R8: flush leaves all pointers coincident
  p_flush_empty_r8: assert property (@(posedge clk) disable iff (rst)
    flush |=> (wr_ptr == ret_ptr) && (iss_ptr == ret_ptr));
  // R7: replay rewinds issue to retire position
  p_replay_rewind_r7: assert property (@(posedge clk) disable iff (rst)
    (replay && !flush) |=> iss_ptr == ret_ptr);
endmodule

// File: rtl/iq_replay_queue.sv
module iq_replay_queue import iq_pkg::*; #(
  parameter int DEPTH = IQ_DEPTH,
  parameter int LANES = IQ_LANES,
  parameter int PORTS = IQ_PORTS,
  parameter int DW    = IQ_DW
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [LANES-1:0]           in_vld,
  input  logic [LANES*DW-1:0]        in_data,
  output logic                       bp_o,
  output logic [PORTS-1:0]           iss_vld_o,
  output logic [PORTS*DW-1:0]        iss_data_o,
  input  logic [PORTS-1:0]           iss_rdy_i,
  input  logic [$clog2(PORTS+1)-1:0] ret_cnt_i,
  input  logic                       replay_i,
  input  logic                       flush_i
);
  localparam int AW  = $clog2(DEPTH);
  localparam int PW  = AW + 1;
  localparam int LCW = $clog2(LANES+1);
  localparam int PCW = $clog2(PORTS+1);

  logic [LANES-1:0]    slot_vld, we;
  logic [LANES*DW-1:0] slot_dat;
  logic [LCW-1:0]      slot_cnt, wr_cnt;
  logic [LANES*AW-1:0] wa;
  logic [PORTS*AW-1:0] ra;
  logic [PW-1:0]       wr_ptr, iss_ptr, ret_ptr, pend;
  logic [PCW-1:0]      iss_cnt;
  logic                accept, run;

  iq_compact #(.LANES(LANES), .DW(DW)) u_compact (
    .lane_vld (in_vld),
    .lane_dat (in_data),
    .slot_vld (slot_vld),
    .slot_dat (slot_dat),
    .count    (slot_cnt)
  );

  assign accept = !bp_o && !flush_i;
  assign we     = slot_vld & {LANES{accept}};
  assign wr_cnt = accept ? slot_cnt : '0;

  for (genvar k = 0; k < LANES; k++) begin : g_wa
    assign wa[k*AW +: AW] = wr_ptr[AW-1:0] + AW'(k);
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_rp
    assign ra[p*AW +: AW] = iss_ptr[AW-1:0] + AW'(p);
    assign iss_vld_o[p]   = pend > PW'(p);
  end

  // accepted ports form an unbroken prefix from port 0
  always_comb begin
    run     = 1'b1;
    iss_cnt = '0;
    for (int p = 0; p < PORTS; p++) begin
      run     = run & iss_vld_o[p] & iss_rdy_i[p];
      iss_cnt = iss_cnt + PCW'(run);
    end
  end

  iq_store #(.DEPTH(DEPTH), .DW(DW), .LANES(LANES), .PORTS(PORTS)) u_store (
    .clk (clk),
    .we  (we),
    .wa  (wa),
    .wd  (slot_dat),
    .ra  (ra),
    .rd  (iss_data_o)
  );

  iq_ptrs #(.DEPTH(DEPTH), .LANES(LANES), .PORTS(PORTS)) u_ptrs (
    .clk     (clk),
    .rst     (rst),
    .wr_cnt  (wr_cnt),
    .iss_cnt (iss_cnt),
    .ret_cnt (ret_cnt_i),
    .replay  (replay_i),
    .flush   (flush_i),
    .wr_ptr  (wr_ptr),
    .iss_ptr (iss_ptr),
    .ret_ptr (ret_ptr),
    .pend    (pend),
    .bp      (bp_o)
  );

  for (genvar p = 1; p < PORTS; p++) begin : g_ord
    // R3: a later port is never valid alone
    p_port_order_r3: assert property (@(posedge clk) disable iff (rst)
      iss_vld_o[p] |-> iss_vld_o[p-1]);
  end

  // R6: no write advances while backpressure is high
  p_bp_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (bp_o && !flush_i) |=> wr_ptr == $past(wr_ptr));
endmodule

// File: tb/tb_iq_replay_queue.sv
module tb_iq_replay_queue;
  localparam int DEPTH = 32;
  localparam int LANES = 4;
  localparam int DW    = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [3:0]   in_vld = '0;
  logic [127:0] in_data = '0;
  logic         bp_o;
  logic [1:0]   iss_vld_o;
  logic [63:0]  iss_data_o;
  logic [1:0]   iss_rdy_i = '0;
  logic [1:0]   ret_cnt_i = '0;
  logic         replay_i = 1'b0;
  logic         flush_i = 1'b0;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic [31:0] seq = 32'h100;

  logic [31:0] mdl[$];   // unretired entries, oldest first
  int          miss = 0; // issued-but-unretired count in mdl

  always #2 clk = ~clk;

  iq_replay_queue dut (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_data(in_data), .bp_o(bp_o),
    .iss_vld_o(iss_vld_o), .iss_data_o(iss_data_o), .iss_rdy_i(iss_rdy_i),
    .ret_cnt_i(ret_cnt_i), .replay_i(replay_i), .flush_i(flush_i)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Driver and monitor in lockstep: compare outputs, then drive and update scoreboard
  task automatic step(input logic [3:0] v, input logic [1:0] rdy, input int ret,
                      input logic rep, input logic fl, input string req);
    bit ev0, ev1, ebp;
    int icnt, nmiss;
    @(negedge clk);
    ebp = (DEPTH - mdl.size()) < LANES;
    ev0 = mdl.size() > miss;
    ev1 = mdl.size() > miss + 1;
    chk(bp_o == ebp, req, "bp", 32'(bp_o), 32'(ebp));
    chk(iss_vld_o[0] == ev0, req, "vld0", 32'(iss_vld_o[0]), 32'(ev0));
    chk(iss_vld_o[1] == ev1, req, "vld1", 32'(iss_vld_o[1]), 32'(ev1));
    if (ev0) chk(iss_data_o[31:0] == mdl[miss], req, "data0", iss_data_o[31:0], mdl[miss]);
    if (ev1) chk(iss_data_o[63:32] == mdl[miss+1], req, "data1", iss_data_o[63:32], mdl[miss+1]);
    if (ret > miss) ret = miss;
    in_vld    = v;
    iss_rdy_i = rdy;
    ret_cnt_i = 2'(ret);
    replay_i  = rep;
    flush_i   = fl;
    for (int l = 0; l < LANES; l++) in_data[l*DW +: DW] = seq + 32'(l);
    icnt = (ev0 && rdy[0]) ? ((ev1 && rdy[1]) ? 2 : 1) : 0;
    if (fl) begin
      mdl.delete();
      miss = 0;
    end else begin
      for (int r = 0; r < ret; r++) void'(mdl.pop_front());
      nmiss = miss + icnt - ret;
      if (rep) nmiss = 0;
      if (!ebp)
        for (int l = 0; l < LANES; l++) if (v[l]) mdl.push_back(seq + 32'(l));
      miss = nmiss;
    end
    seq = seq + 32'h10;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        $display("FAIL watchdog: actual %0d expected below %0d", cycles, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    step(4'b0000, 2'b00, 0, 0, 0, "R1");
    // R2: compaction with squashed lanes
    step(4'b1111, 2'b00, 0, 0, 0, "R2");
    step(4'b1010, 2'b00, 0, 0, 0, "R2");
    step(4'b0110, 2'b00, 0, 0, 0, "R2");
    step(4'b0001, 2'b00, 0, 0, 0, "R2");
    step(4'b0000, 2'b00, 0, 0, 0, "R2");
    // R4: port 1 ready alone issues nothing
    step(4'b0000, 2'b10, 0, 0, 0, "R4");
    step(4'b0000, 2'b11, 0, 0, 0, "R3");
    step(4'b0000, 2'b01, 0, 0, 0, "R3");
    step(4'b0000, 2'b11, 0, 0, 0, "R4");
    // R5: entries persist after issue, retire frees oldest
    step(4'b0000, 2'b00, 2, 0, 0, "R5");
    // R7: replay with same-cycle retirement
    step(4'b0000, 2'b11, 1, 1, 0, "R7");
    step(4'b0000, 2'b00, 0, 0, 0, "R7");
    step(4'b0000, 2'b11, 0, 0, 0, "R7");
    // R6: fill until backpressure, writes dropped meanwhile
    for (int i = 0; i < 10; i++) step(4'b1111, 2'b00, 0, 0, 0, "R6");
    step(4'b0000, 2'b00, 0, 0, 0, "R6");
    for (int i = 0; i < 20; i++) step(4'b0000, 2'b11, 2, 0, 0, "R5");
    // R8: flush beats replay, retire and writes
    step(4'b1111, 2'b00, 0, 0, 0, "R8");
    step(4'b1111, 2'b11, 0, 0, 0, "R8");
    step(4'b1111, 2'b11, 1, 1, 1, "R8");
    step(4'b0000, 2'b00, 0, 0, 0, "R8");
    // R9: long random run across many wraps
    for (int i = 0; i < 4000; i++)
      step(4'($urandom), 2'($urandom), int'($urandom % 3),
           ($urandom % 29) == 0, ($urandom % 211) == 0, "R9");
    step(4'b0000, 2'b00, 0, 0, 0, "R9");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule